// File: doc/BRIEF.md
# Foldback PWM Timing Generator

This block produces the switching period and the gate timing for a synchronous step-down power stage. Each period it reads a digitised feedback code and an on-time request from the current-mode loop. It turns these into a high-side gate window, a low-side gate window and a one-clock strobe that marks the start of the period. The strobe lets the peak-current comparator logic re-arm for the new cycle.

At regulation the period is short, which gives the nominal 500 kHz switching rate with a 100 MHz clock. As the feedback code falls toward zero, as happens during an output short, the period stretches linearly to the 80 kHz foldback rate. The inductor then has time to discharge between pulses. The same phase counter enforces the duty-cycle ceiling, the minimum on-pulse and the break-before-make gap between the two gates.

The timer runs through five phases: `PH_IDLE`, then `PH_LEAD_GAP`, `PH_HIGH`, `PH_TRAIL_GAP` and `PH_LOW`. The transitions are:
- `PH_IDLE` moves to `PH_LEAD_GAP` on enable, and latches the new period and on-time at that point.
- `PH_LEAD_GAP` moves to `PH_HIGH` after the dead time.
- `PH_HIGH` moves to `PH_TRAIL_GAP` after the on-time.
- `PH_TRAIL_GAP` moves to `PH_LOW` after the dead time. If the period is already used up, it goes straight back to `PH_LEAD_GAP` with a new latch.
- `PH_LOW` moves to `PH_LEAD_GAP` with a new latch at the last count of the period.
- Any phase moves to `PH_IDLE` when enable is low.

Top module: `foldback_pwm_timer`

## Requirements
- R1: While enable is low (sampled at a clock edge), both gates and the strobe are low from the next cycle on, and the phase counter is cleared. After enable is sampled high, the strobe appears in the following cycle and a full fresh period begins.
- R2: With a feedback code of 800 or above, every period lasts 200 clocks.
- R3: With a feedback code of 0, every period lasts 1250 clocks.
- R4: The period in clocks is 1250 − floor(1050 × min(code, 800) / 800).
- R5: The period length and on-time are taken only at a period start. A feedback change in mid-period leaves the running period's length unchanged and takes effect from the next period.
- R6: The granted on-time never exceeds the smaller of floor(period × 99 / 100) and period − 4 (room for both dead gaps).
- R7: An on-time request below 15 clocks (150 ns), including 0, is extended to 15 clocks.
- R8: The two gates are never high together. At least 2 clocks (20 ns) with both gates low separate a fall of either gate from a rise of the other.
- R9: The strobe is high for exactly one clock at the start of each period, and in that clock both gates are low.
- R10: A request inside the allowed window is granted exactly. The high-side gate rises 2 clocks after the strobe clock and stays high for the granted number of clocks.
- R11: The low-side gate rises 2 clocks after the high-side gate falls and stays high through the last clock of the period. It is absent when the on-time takes the whole usable window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (100 MHz assumed for the default counts) |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter run enable |
| fb_code_i | input | FB_W (10) | Digitised feedback level, reference reads as 800 |
| on_req_i | input | PER_W (11) | Requested high-side on-time in clocks |
| hs_gate_o | output | 1 | High-side switch gate command |
| ls_gate_o | output | 1 | Low-side switch gate command |
| period_start_o | output | 1 | One-clock strobe at each period start |

## Verification
The hardest state to reach is a feedback change that lands in the middle of a long foldback period. The check must then show that the running period keeps its latched length while the next one takes the new value. The bench reaches it by running a full 1250-clock period at code 0, then raising the code to the reference 30 clocks into the next period. It counts the period to the next strobe and the one after that. A second hard case is cutting enable while the high-side gate is on. The bench waits until the gate is seen high, drops enable, and then checks that the restart begins a full period from count zero.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    // Phases of one switching period
    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_LEAD_GAP  = 3'd1,
        PH_HIGH      = 3'd2,
        PH_TRAIL_GAP = 3'd3,
        PH_LOW       = 3'd4
    } phase_t;

    // Returns the smaller of two unsigned values
    function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/fpt_period_map.sv
module fpt_period_map #(
    parameter int FB_W    = 10,
    parameter int FB_REF  = 800,
    parameter int PER_NOM = 200,
    parameter int PER_MAX = 1250,
    parameter int PER_W   = 11
) (
    input  logic [FB_W-1:0]  fb_code,
    output logic [PER_W-1:0] period
);

    localparam int SPAN     = PER_MAX - PER_NOM;
    localparam bit REF_POW2 = ((FB_REF & (FB_REF - 1)) == 0);
    localparam int REF_SH   = $clog2(FB_REF);

    logic [31:0] fb_sat;
    logic [31:0] product;
    logic [31:0] drop;

    // Feedback above the reference is treated as being at the reference
    always_comb begin
        fb_sat  = (32'(fb_code) > 32'(FB_REF)) ? 32'(FB_REF) : 32'(fb_code);
        product = 32'(SPAN) * fb_sat;
    end

    // Scale back by the reference: a shift when it is a power of two
    generate
        if (REF_POW2) begin : g_shift
            assign drop = product >> REF_SH;
        end else begin : g_divide
            assign drop = product / 32'(FB_REF);
        end
    endgenerate

    assign period = PER_W'(32'(PER_MAX) - drop);

endmodule

// File: rtl/fpt_ontime_limit.sv
module fpt_ontime_limit #(
    parameter int PER_W    = 11,
    parameter int DUTY_PCT = 99,
    parameter int MIN_ON   = 15,
    parameter int DEAD     = 2
) (
    input  logic [PER_W-1:0] on_req,
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] ontime
);
    import fpt_pkg::*;

    logic [31:0] duty_cap;
    logic [31:0] gap_cap;
    logic [31:0] ceiling;
    logic [31:0] granted;

    always_comb begin
        duty_cap = (32'(period) * 32'(DUTY_PCT)) / 32'd100;
        gap_cap  = 32'(period) - 32'(2 * DEAD);
        ceiling  = umin(duty_cap, gap_cap);
        if (32'(on_req) < 32'(MIN_ON)) begin
            granted = 32'(MIN_ON);
        end else if (32'(on_req) > ceiling) begin
            granted = ceiling;
        end else begin
            granted = 32'(on_req);
        end
        ontime = PER_W'(granted);
    end

endmodule

// File: rtl/fpt_phase_seq.sv
module fpt_phase_seq #(
    parameter int PER_W   = 11,
    parameter int DEAD    = 2,
    parameter int MIN_ON  = 15,
    parameter int PER_NOM = 200,
    parameter int PER_MAX = 1250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period_in,
    input  logic [PER_W-1:0] ontime_in,
    output logic             hs_o,
    output logic             ls_o,
    output logic             strobe_o
);
    import fpt_pkg::*;

    phase_t           phase_q, phase_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic [PER_W-1:0] per_lat, on_lat;
    logic             load;

    logic [PER_W-1:0] lead_end;
    logic [PER_W-1:0] high_end;
    logic [PER_W-1:0] trail_end;
    logic             period_last;

    assign lead_end    = PER_W'(DEAD - 1);
    assign high_end    = on_lat + PER_W'(DEAD - 1);
    assign trail_end   = on_lat + PER_W'(2 * DEAD - 1);
    assign period_last = (cnt_q == per_lat - PER_W'(1));

    // State register with period latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            per_lat <= PER_W'(PER_NOM);
            on_lat  <= PER_W'(MIN_ON);
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            if (load) begin
                per_lat <= period_in;
                on_lat  <= ontime_in;
            end
        end
    end

    // Next phase
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q + PER_W'(1);
        load    = 1'b0;
        if (!en) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_LEAD_GAP;
                    cnt_d   = '0;
                    load    = 1'b1;
                end
                PH_LEAD_GAP: begin
                    if (cnt_q == lead_end) phase_d = PH_HIGH;
                end
                PH_HIGH: begin
                    if (cnt_q == high_end) phase_d = PH_TRAIL_GAP;
                end
                PH_TRAIL_GAP: begin
                    if (cnt_q == trail_end) begin
                        if (period_last) begin
                            phase_d = PH_LEAD_GAP;
                            cnt_d   = '0;
                            load    = 1'b1;
                        end else begin
                            phase_d = PH_LOW;
                        end
                    end
                end
                PH_LOW: begin
                    if (period_last) begin
                        phase_d = PH_LEAD_GAP;
                        cnt_d   = '0;
                        load    = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs decoded from the registered phase
    always_comb begin
        hs_o     = (phase_q == PH_HIGH);
        ls_o     = (phase_q == PH_LOW);
        strobe_o = (phase_q == PH_LEAD_GAP) && (cnt_q == '0);
    end

    AST_LOAD_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (32'(period_in) >= 32'(PER_NOM) && 32'(period_in) <= 32'(PER_MAX))); // R4
    AST_LOAD_ONTIME_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (32'(ontime_in) >= 32'(MIN_ON) && 32'(ontime_in) + 32'(2 * DEAD) <= 32'(period_in))); // R6

endmodule

// File: rtl/foldback_pwm_timer.sv
module foldback_pwm_timer #(
    parameter int FB_W     = 10,
    parameter int FB_REF   = 800,
    parameter int PER_NOM  = 200,
    parameter int PER_MAX  = 1250,
    parameter int DUTY_PCT = 99,
    parameter int MIN_ON   = 15,
    parameter int DEAD     = 2,
    localparam int PER_W   = $clog2(PER_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [FB_W-1:0]  fb_code_i,
    input  logic [PER_W-1:0] on_req_i,
    output logic             hs_gate_o,
    output logic             ls_gate_o,
    output logic             period_start_o
);

    localparam int RUN_W = $clog2(DEAD + 2);

    logic [PER_W-1:0] period_w;
    logic [PER_W-1:0] ontime_w;

    fpt_period_map #(
        .FB_W(FB_W), .FB_REF(FB_REF), .PER_NOM(PER_NOM),
        .PER_MAX(PER_MAX), .PER_W(PER_W)
    ) u_map (
        .fb_code(fb_code_i),
        .period (period_w)
    );

    fpt_ontime_limit #(
        .PER_W(PER_W), .DUTY_PCT(DUTY_PCT), .MIN_ON(MIN_ON), .DEAD(DEAD)
    ) u_limit (
        .on_req(on_req_i),
        .period(period_w),
        .ontime(ontime_w)
    );

    fpt_phase_seq #(
        .PER_W(PER_W), .DEAD(DEAD), .MIN_ON(MIN_ON),
        .PER_NOM(PER_NOM), .PER_MAX(PER_MAX)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_i),
        .period_in(period_w),
        .ontime_in(ontime_w),
        .hs_o     (hs_gate_o),
        .ls_o     (ls_gate_o),
        .strobe_o (period_start_o)
    );

    // Run-length counters observed at the gate outputs
    logic [RUN_W-1:0] off_run;
    logic [PER_W-1:0] hs_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run <= '0;
            hs_run  <= '0;
        end else begin
            if (hs_gate_o || ls_gate_o) off_run <= '0;
            else if (off_run != {RUN_W{1'b1}}) off_run <= off_run + RUN_W'(1);
            if (hs_gate_o) hs_run <= hs_run + PER_W'(1);
            else hs_run <= '0;
        end
    end

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o)); // R8
    AST_GAP_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> 32'(off_run) >= 32'(DEAD)); // R8
    AST_GAP_BEFORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |-> 32'(off_run) >= 32'(DEAD)); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!hs_gate_o && !ls_gate_o && !period_start_o)); // R1
    AST_STROBE_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> (!hs_gate_o && !ls_gate_o)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |=> !period_start_o); // R9
    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_gate_o) && $past(en_i)) |-> 32'(hs_run) >= 32'(MIN_ON)); // R7

endmodule

// File: tb/sim_foldback_pwm_timer.sv
module sim_foldback_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [9:0]  fb = '0;
    logic [10:0] req = '0;
    logic        hs, ls, stb;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    foldback_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .fb_code_i(fb), .on_req_i(req),
        .hs_gate_o(hs), .ls_gate_o(ls), .period_start_o(stb)
    );

    // Vectors: feedback code, request, expected period, expected on-time
    localparam int NV = 12;
    localparam int VEC [NV][4] = '{
        '{800,  100,  200,  100},   // R2 R10 nominal
        '{1023, 50,   200,  50},    // R2 above reference
        '{0,    600,  1250, 600},   // R3 full foldback
        '{400,  300,  725,  300},   // R4 midpoint
        '{400,  5,    725,  15},    // R7 short request
        '{800,  0,    200,  15},    // R7 zero request
        '{800,  2000, 200,  196},   // R6 gap ceiling
        '{0,    2047, 1250, 1237},  // R6 duty ceiling
        '{100,  200,  1119, 200},   // R4
        '{799,  14,   202,  15},    // R4 R7
        '{1,    15,   1249, 15},    // R4 R7 exact floor
        '{720,  500,  305,  301}    // R6 duty ceiling
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Measures one period from a strobe to the next strobe
    task automatic run_period(input bit skip_wait, input int mid_at, input int mid_fb,
                              output int per, output int hs_len, output int hs_first,
                              output int ls_len, output int ls_first, output int overlap,
                              output int stb_bad);
        if (!skip_wait) begin
            @(negedge clk);
            while (stb !== 1'b1) @(negedge clk);
        end
        per = 0; hs_len = 0; hs_first = -1; ls_len = 0; ls_first = -1; overlap = 0;
        stb_bad = (hs || ls) ? 1 : 0;
        do begin
            if (hs) begin
                if (hs_first < 0) hs_first = per;
                hs_len++;
            end
            if (ls) begin
                if (ls_first < 0) ls_first = per;
                ls_len++;
            end
            if (hs && ls) overlap++;
            if (per == mid_at) fb = 10'(mid_fb);
            per++;
            @(negedge clk);
        end while (stb !== 1'b1);
    endtask

    task automatic check_period(input int ep, input int et, input int per, input int hl,
                                input int hf, input int ll, input int lf, input int ov,
                                input int sb);
        chk(per == ep, "R4 period length", per, ep);
        chk(hl == et, "R10 high-side length (R6/R7 limits)", hl, et);
        chk(hf == 2, "R10 high-side start after strobe", hf, 2);
        chk(ll == ep - 4 - et, "R11 low-side length", ll, ep - 4 - et);
        if (ll > 0) chk(lf == et + 4, "R8 gap before low-side", lf, et + 4);
        chk(ov == 0, "R8 gate overlap count", ov, 0);
        chk(sb == 0, "R9 gates low at strobe", sb, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int per, hl, hf, ll, lf, ov, sb;
        // R1 reset and disabled state
        repeat (4) @(negedge clk);
        chk(!hs && !ls && !stb, "R1 outputs low in reset", {29'd0, hs, ls, stb}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!hs && !ls && !stb, "R1 outputs low while disabled", {29'd0, hs, ls, stb}, 0);
        end

        fb = 10'd800; req = 11'd100; en = 1'b1;
        @(negedge clk);
        chk(stb == 1'b1, "R1 strobe one clock after enable", int'(stb), 1);

        // Table walk (R2 R3 R4 R6 R7 R10 R11)
        for (int v = 0; v < NV; v++) begin
            fb  = 10'(VEC[v][0]);
            req = 11'(VEC[v][1]);
            run_period(1'b0, -1, 0, per, hl, hf, ll, lf, ov, sb);
            check_period(VEC[v][2], VEC[v][3], per, hl, hf, ll, lf, ov, sb);
        end

        // R5: mid-period feedback change does not cut the running period
        fb = 10'd0; req = 11'd100;
        run_period(1'b0, -1, 0, per, hl, hf, ll, lf, ov, sb);
        run_period(1'b1, 30, 800, per, hl, hf, ll, lf, ov, sb);
        chk(per == 1250, "R5 running period keeps latched length", per, 1250);
        run_period(1'b1, -1, 0, per, hl, hf, ll, lf, ov, sb);
        chk(per == 200, "R5 next period uses new feedback", per, 200);

        // R1: cut enable while high side is on, then restart
        @(negedge clk);
        while (hs !== 1'b1) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!hs && !ls && !stb, "R1 gates drop after enable low", {29'd0, hs, ls, stb}, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!hs && !ls && !stb, "R1 quiet while disabled", {29'd0, hs, ls, stb}, 0);
        end
        en = 1'b1;
        @(negedge clk);
        chk(stb == 1'b1, "R9 strobe after re-enable", int'(stb), 1);
        run_period(1'b1, -1, 0, per, hl, hf, ll, lf, ov, sb);
        chk(per == 200, "R1 fresh full period after restart", per, 200);
        chk(hf == 2, "R1 counter restarted from zero", hf, 2);

        finish_run();
    end

endmodule